// File: doc/BRIEF.md
# Accumulator Instruction Executor

This block is a small 8-bit accumulator execution unit that runs a subset of an instruction set. An 11-bit program counter drives an external program memory with a combinational read port. The word that comes back is latched into an instruction register and executed on the next clock. The block therefore fetches one instruction and executes the one before it in every cycle. The executor holds a 64-entry register file, the accumulator, a zero flag, a four-entry return stack and three I/O control registers.

There are five operations:
- increment a register and skip the next instruction when the result is zero;
- OR the accumulator with a register;
- OR the accumulator with an immediate;
- copy the accumulator into one of the I/O control registers;
- a software interrupt call.

When an increment produces zero, the instruction already fetched is replaced with a bubble. The software interrupt pushes its return address and jumps to address 2. It then spends either one or two extra bubble cycles, as chosen by a parameter.

Top module: `acc_exec_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter (so `imem_addr` is 0), the accumulator, the zero flag, every register file entry, the stack pointer, the stack entries and the three I/O control registers. After reset the first instruction executed is the one at address 0, and it executes two clock edges after reset is released.
- R2: The instruction word is 14 bits, and bits 13:8 are the opcode. Every opcode other than the five listed below is a one-cycle no-operation. With no skip and no interrupt, `imem_addr` advances by one on every clock.
- R3: Opcode 0x0F increments a register. Bits 5:0 select the register and bit 6 selects the destination (0 = accumulator, 1 = the same register). The register value plus one, modulo 256, is written to the destination, and the zero flag keeps its value.
- R4: When the opcode 0x0F result is zero, the instruction fetched behind it is discarded. The instruction then takes two cycles, and execution continues at its address plus two.
- R5: Opcode 0x04 ORs the accumulator with the register named in bits 5:0. The result goes to the destination that bit 6 selects, and the zero flag is set exactly when the result is zero.
- R6: Opcode 0x34 ORs the accumulator with the immediate in bits 7:0. The result is written to the accumulator, and the zero flag is set exactly when the result is zero.
- R7: Opcode 0x01 copies the accumulator into I/O control register 5, 6 or 7, chosen by bits 5:0. Any other value in bits 5:0 changes nothing, and the flags are unchanged.
- R8: Opcode 0x02 pushes its own address plus one and moves execution to address 2. It occupies `SWI_CYCLES` cycles (2 or 3), and `imem_addr` holds at 2 during any extra stall cycle.
- R9: The return stack holds four 11-bit entries, and `ret_top_o` shows the most recent push. A fifth push overwrites the oldest entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 11 | Program memory read address (program counter) |
| imem_data | input | 14 | Instruction word read at `imem_addr` |
| acc_o | output | 8 | Accumulator |
| zero_o | output | 1 | Zero flag |
| ioctl5_o | output | 8 | I/O control register 5 |
| ioctl6_o | output | 8 | I/O control register 6 |
| ioctl7_o | output | 8 | I/O control register 7 |
| ret_top_o | output | 11 | Most recently pushed return address |

## Verification
A directed prologue at address 2 covers three corners:
- an immediate OR that yields zero, which separates a set zero flag from a stale one;
- a register set to 0xFF and then incremented to both destinations, which separates the skip path from the plain increment path;
- an I/O load to address 4, which shows that unlisted addresses are ignored.

Random code follows the prologue. It mixes OR and increment operations on a small set of registers, so that writes to a register are often followed at once by reads of it. This reveals stale register or accumulator values. Software interrupts are scattered through the random code, and a forced interrupt sits at the end, so the program loops many times. This wraps the return stack and tells the push order and the stall length apart.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    localparam int INSN_W  = 14;
    localparam int OPC_W   = 6;
    localparam int OPC_LSB = 8;
    localparam int OPR_W   = 6;
    localparam int IMM_W   = 8;
    localparam int DSEL_BIT = 6;

    localparam logic [OPC_W-1:0] OPC_IOLD  = 6'h01;
    localparam logic [OPC_W-1:0] OPC_SWI   = 6'h02;
    localparam logic [OPC_W-1:0] OPC_ORR   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_INCSZ = 6'h0F;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h34;

    localparam logic [INSN_W-1:0] INSN_NOP = '0;

    // first I/O control register address; three consecutive ones follow
    localparam int IO_BASE  = 5;
    localparam int IO_COUNT = 3;

    typedef enum logic [2:0] {
        K_NOP,
        K_INCSZ,
        K_ORR,
        K_ORI,
        K_IOLD,
        K_SWI
    } op_kind_e;

    typedef struct packed {
        op_kind_e           kind;
        logic               to_reg;
        logic [OPR_W-1:0]   ridx;
        logic [IMM_W-1:0]   imm;
    } dec_t;

endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
    import acc_exec_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc        = insn[OPC_LSB +: OPC_W];
        dec.to_reg = insn[DSEL_BIT];
        dec.ridx   = insn[OPR_W-1:0];
        dec.imm    = insn[IMM_W-1:0];
        unique case (opc)
            OPC_INCSZ: dec.kind = K_INCSZ;
            OPC_ORR:   dec.kind = K_ORR;
            OPC_ORI:   dec.kind = K_ORI;
            OPC_IOLD:  dec.kind = K_IOLD;
            OPC_SWI:   dec.kind = K_SWI;
            default:   dec.kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/acc_exec_regfile.sv
module acc_exec_regfile #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        rd_data = mem_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/acc_exec_retstack.sv
module acc_exec_retstack #(
    parameter int WIDTH = 11,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_val,
    output logic [WIDTH-1:0] top
);

    typedef struct packed {
        logic [PW-1:0]                ptr;
        logic [DEPTH-1:0][WIDTH-1:0]  ent;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.ent[st_q.ptr] = push_val;
            st_d.ptr           = st_q.ptr + 1'b1;
        end
        top = st_q.ent[st_q.ptr - 1'b1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/acc_exec_core.sv
module acc_exec_core
    import acc_exec_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PC_W       = 11,
    parameter int REG_CNT    = 64,
    parameter int STK_DEPTH  = 4,
    parameter int SWI_CYCLES = 2,
    parameter int SWI_VEC    = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [INSN_W-1:0] imem_data,
    output logic [DATA_W-1:0] acc_o,
    output logic              zero_o,
    output logic [DATA_W-1:0] ioctl5_o,
    output logic [DATA_W-1:0] ioctl6_o,
    output logic [DATA_W-1:0] ioctl7_o,
    output logic [PC_W-1:0]   ret_top_o
);

    localparam int RF_AW = $clog2(REG_CNT);
    localparam int WC_W  = $clog2(SWI_CYCLES);

    typedef struct packed {
        logic [PC_W-1:0]                    pc;
        logic [INSN_W-1:0]                  ir;
        logic [DATA_W-1:0]                  acc;
        logic                               zf;
        logic [WC_W-1:0]                    wcnt;
        logic [IO_COUNT-1:0][DATA_W-1:0]    io;
    } core_st_t;

    core_st_t          st_d, st_q;
    dec_t              dec;
    logic [DATA_W-1:0] rf_rdata;
    logic              rf_we;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] res;
    logic              push;
    logic              skip_now;

    acc_exec_decode u_dec (
        .insn (st_q.ir),
        .dec  (dec)
    );

    acc_exec_regfile #(
        .WIDTH (DATA_W),
        .DEPTH (REG_CNT)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (dec.ridx[RF_AW-1:0]),
        .rd_data (rf_rdata),
        .wr_en   (rf_we),
        .wr_idx  (dec.ridx[RF_AW-1:0]),
        .wr_data (rf_wdata)
    );

    acc_exec_retstack #(
        .WIDTH (PC_W),
        .DEPTH (STK_DEPTH)
    ) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_val (st_q.pc),
        .top      (ret_top_o)
    );

    always_comb begin
        st_d     = st_q;
        rf_we    = 1'b0;
        rf_wdata = '0;
        push     = 1'b0;
        skip_now = 1'b0;
        res      = '0;

        // fetch side: stall cycles after an interrupt hold the PC
        if (st_q.wcnt != '0) begin
            st_d.ir   = INSN_NOP;
            st_d.wcnt = st_q.wcnt - 1'b1;
        end else begin
            st_d.ir = imem_data;
            st_d.pc = st_q.pc + 1'b1;
        end

        // execute side
        unique case (dec.kind)
            K_INCSZ: begin
                res = rf_rdata + 1'b1;
                if (dec.to_reg) begin
                    rf_we    = 1'b1;
                    rf_wdata = res;
                end else begin
                    st_d.acc = res;
                end
                if (res == '0) begin
                    skip_now = 1'b1;
                    st_d.ir  = INSN_NOP;
                end
            end
            K_ORR: begin
                res = st_q.acc | rf_rdata;
                if (dec.to_reg) begin
                    rf_we    = 1'b1;
                    rf_wdata = res;
                end else begin
                    st_d.acc = res;
                end
                st_d.zf = (res == '0);
            end
            K_ORI: begin
                res      = st_q.acc | DATA_W'(dec.imm);
                st_d.acc = res;
                st_d.zf  = (res == '0);
            end
            K_IOLD: begin
                for (int i = 0; i < IO_COUNT; i++) begin
                    if (dec.ridx == OPR_W'(IO_BASE + i)) begin
                        st_d.io[i] = st_q.acc;
                    end
                end
            end
            K_SWI: begin
                push      = 1'b1;
                st_d.pc   = PC_W'(SWI_VEC);
                st_d.ir   = INSN_NOP;
                st_d.wcnt = WC_W'(SWI_CYCLES - 2);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        imem_addr = st_q.pc;
        acc_o     = st_q.acc;
        zero_o    = st_q.zf;
        ioctl5_o  = st_q.io[0];
        ioctl6_o  = st_q.io[1];
        ioctl7_o  = st_q.io[2];
    end

endmodule

// File: rtl/acc_exec_core_chk.sv
module acc_exec_core_chk
    import acc_exec_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PC_W    = 11,
    parameter int SWI_VEC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [PC_W-1:0]   imem_addr,
    input logic [DATA_W-1:0] acc_o,
    input logic              zero_o,
    input logic [DATA_W-1:0] ioctl5_o,
    input logic [PC_W-1:0]   ret_top_o,
    input logic [INSN_W-1:0] ir,
    input logic              wait_idle,
    input logic              skip
);

    logic [OPC_W-1:0] opc;
    assign opc = ir[OPC_LSB +: OPC_W];

    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> (imem_addr == '0 && acc_o == '0 && !zero_o && ioctl5_o == '0));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (opc != OPC_SWI && !skip && wait_idle)
        |=> imem_addr == PC_W'($past(imem_addr) + 1'b1));

    p_zero_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_INCSZ) |=> $stable(zero_o));

    p_skip_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        skip |=> (ir == INSN_NOP));

    p_ori_result_r6: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_ORI)
        |=> (acc_o == ($past(acc_o) | DATA_W'($past(ir[IMM_W-1:0])))
             && zero_o == (acc_o == '0)));

    p_io5_load_r7: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_IOLD && ir[OPR_W-1:0] == OPR_W'(IO_BASE))
        |=> ioctl5_o == $past(acc_o));

    p_swi_vector_r8: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_SWI) |=> imem_addr == PC_W'(SWI_VEC));

    p_swi_stall_r8: assert property (@(posedge clk) disable iff (rst)
        !wait_idle |=> $stable(imem_addr));

    p_swi_push_r9: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_SWI) |=> ret_top_o == $past(imem_addr));

endmodule

bind acc_exec_core acc_exec_core_chk #(
    .DATA_W  (DATA_W),
    .PC_W    (PC_W),
    .SWI_VEC (SWI_VEC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .acc_o     (acc_o),
    .zero_o    (zero_o),
    .ioctl5_o  (ioctl5_o),
    .ret_top_o (ret_top_o),
    .ir        (st_q.ir),
    .wait_idle (st_q.wcnt == '0),
    .skip      (skip_now)
);

// File: tb/acc_exec_core_test.sv
module acc_exec_core_test;
    import acc_exec_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SWI_CYC    = 3;
    localparam int RUN_CYCLES = 3000;
    localparam int PROG_LEN   = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] imem_addr;
    logic [13:0] imem_data;
    logic [7:0]  acc_o, ioctl5_o, ioctl6_o, ioctl7_o;
    logic        zero_o;
    logic [10:0] ret_top_o;

    logic [13:0] prog [PROG_LEN];

    int n_chk  = 0;
    int n_fail = 0;
    int n_skip = 0;
    int n_swi  = 0;

    // reference model state
    logic [10:0] m_pc;
    int          m_bub;
    logic [7:0]  m_acc;
    logic        m_z;
    logic [7:0]  m_rf [64];
    logic [7:0]  m_io [3];
    logic [10:0] m_stk [4];
    logic [1:0]  m_sp;
    string       m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_data = (imem_addr < 11'(PROG_LEN)) ? prog[imem_addr[5:0]] : 14'h0;

    acc_exec_core #(.SWI_CYCLES(SWI_CYC)) uut (
        .clk       (clk),
        .rst       (rst),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .acc_o     (acc_o),
        .zero_o    (zero_o),
        .ioctl5_o  (ioctl5_o),
        .ioctl6_o  (ioctl6_o),
        .ioctl7_o  (ioctl7_o),
        .ret_top_o (ret_top_o)
    );

    function automatic logic [13:0] enc_r(logic [5:0] op, logic d, logic [5:0] r);
        return {op, 1'b0, d, r};
    endfunction

    function automatic logic [13:0] enc_i(logic [5:0] op, logic [7:0] imm);
        return {op, imm};
    endfunction

    function automatic logic [13:0] fetch(logic [10:0] a);
        return (a < 11'(PROG_LEN)) ? prog[a[5:0]] : 14'h0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic model_tick;
        logic [13:0] w;
        logic [5:0]  op, r;
        logic        d;
        logic [7:0]  res;
        if (m_bub > 0) begin
            m_bub--;
            m_tag = "R2";
        end else begin
            w  = fetch(m_pc);
            op = w[13:8];
            d  = w[6];
            r  = w[5:0];
            case (op)
                6'h0F: begin
                    res = m_rf[r] + 8'd1;
                    if (d) m_rf[r] = res; else m_acc = res;
                    if (res == 8'd0) begin
                        m_pc = m_pc + 11'd2; m_bub = 1; m_tag = "R4"; n_skip++;
                    end else begin
                        m_pc = m_pc + 11'd1; m_tag = "R3";
                    end
                end
                6'h04: begin
                    res = m_acc | m_rf[r];
                    if (d) m_rf[r] = res; else m_acc = res;
                    m_z = (res == 8'd0);
                    m_pc = m_pc + 11'd1; m_tag = "R5";
                end
                6'h34: begin
                    m_acc = m_acc | w[7:0];
                    m_z = (m_acc == 8'd0);
                    m_pc = m_pc + 11'd1; m_tag = "R6";
                end
                6'h01: begin
                    if (r >= 6'd5 && r <= 6'd7) m_io[r - 6'd5] = m_acc;
                    m_pc = m_pc + 11'd1; m_tag = "R7";
                end
                6'h02: begin
                    m_stk[m_sp] = m_pc + 11'd1;
                    m_sp = m_sp + 2'd1;
                    m_pc = 11'd2;
                    m_bub = SWI_CYC - 1;
                    m_tag = "R8"; n_swi++;
                end
                default: begin
                    m_pc = m_pc + 11'd1; m_tag = "R2";
                end
            endcase
        end
    endtask

    task automatic compare_all;
        logic [10:0] exp_addr;
        exp_addr = (m_bub > 0) ? m_pc : m_pc + 11'd1;
        chk(m_tag, "imem_addr", int'(imem_addr), int'(exp_addr));
        chk(m_tag, "acc", int'(acc_o), int'(m_acc));
        chk(m_tag, "zero", int'(zero_o), int'(m_z));
        chk("R7", "ioctl5", int'(ioctl5_o), int'(m_io[0]));
        chk("R7", "ioctl6", int'(ioctl6_o), int'(m_io[1]));
        chk("R7", "ioctl7", int'(ioctl7_o), int'(m_io[2]));
        chk("R9", "ret_top", int'(ret_top_o), int'(m_stk[m_sp - 2'd1]));
    endtask

    task automatic build_program;
        int k;
        void'($urandom(32'd715));
        for (int i = 0; i < PROG_LEN; i++) prog[i] = 14'h0;
        // directed prologue
        prog[2]  = enc_i(OPC_ORI, 8'h00);          // zero result sets Z (R6)
        prog[3]  = enc_r(OPC_IOLD, 1'b0, 6'd5);
        prog[4]  = enc_i(OPC_ORI, 8'hA5);
        prog[5]  = enc_r(OPC_IOLD, 1'b0, 6'd6);
        prog[6]  = enc_r(OPC_IOLD, 1'b0, 6'd4);    // ignored address (R7)
        prog[7]  = enc_r(OPC_ORR, 1'b1, 6'd9);
        prog[8]  = enc_i(OPC_ORI, 8'hFF);
        prog[9]  = enc_r(OPC_ORR, 1'b1, 6'd10);    // r10 = FF
        prog[10] = enc_r(OPC_INCSZ, 1'b0, 6'd10);  // acc = 0, skip (R4)
        prog[11] = enc_i(OPC_ORI, 8'h11);
        prog[12] = enc_r(OPC_INCSZ, 1'b1, 6'd10);  // r10 = 0, skip
        prog[13] = enc_r(OPC_IOLD, 1'b0, 6'd7);
        prog[14] = enc_r(OPC_IOLD, 1'b0, 6'd7);
        prog[15] = enc_r(OPC_ORR, 1'b0, 6'd10);
        prog[16] = enc_r(OPC_INCSZ, 1'b1, 6'd9);
        prog[17] = {6'h3F, 8'h5A};                 // unknown opcode (R2)
        for (int a = 18; a < PROG_LEN - 1; a++) begin
            k = int'($urandom % 16);
            if (k < 4)
                prog[a] = enc_r(OPC_INCSZ, 1'($urandom), 6'($urandom % 8));
            else if (k < 8)
                prog[a] = enc_r(OPC_ORR, 1'($urandom), 6'($urandom % 8));
            else if (k < 11)
                prog[a] = enc_i(OPC_ORI, 8'($urandom));
            else if (k < 13)
                prog[a] = enc_r(OPC_IOLD, 1'b0, 6'(4 + $urandom % 4));
            else if (k == 13)
                prog[a] = enc_r(OPC_SWI, 1'b0, 6'd0);
            else
                prog[a] = 14'($urandom);
        end
        prog[PROG_LEN-1] = enc_r(OPC_SWI, 1'b0, 6'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        build_program();
        m_pc = '0; m_bub = 1; m_acc = '0; m_z = 1'b0; m_sp = '0; m_tag = "R1";
        for (int i = 0; i < 64; i++) m_rf[i] = '0;
        for (int i = 0; i < 3; i++) m_io[i] = '0;
        for (int i = 0; i < 4; i++) m_stk[i] = '0;

        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "imem_addr", int'(imem_addr), 0);
        chk("R1", "acc", int'(acc_o), 0);
        chk("R1", "zero", int'(zero_o), 0);
        chk("R1", "ioctl5", int'(ioctl5_o), 0);
        chk("R1", "ret_top", int'(ret_top_o), 0);
        rst = 1'b0;

        for (int c = 0; c < RUN_CYCLES; c++) begin
            @(posedge clk);
            model_tick();
            @(negedge clk);
            compare_all();
        end

        chk("R4", "skips_seen_nonzero", int'(n_skip > 0), 1);
        chk("R9", "swi_count_wraps_stack", int'(n_swi >= 5), 1);
        report();
    end

endmodule